// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block holds the exception state and operating controls that sit next to a floating-point arithmetic unit. Each time the unit finishes an operation, it reports which of five standard exceptions occurred: inexact, underflow, divide-by-zero, overflow and invalid. It also reports whether the operation is not implemented in hardware. The register records these reports in two ways. Accumulating flags stay set until software clears them. Cause bits describe only the most recent operation.

Software reads and writes the whole 32-bit word through a simple port. Through that port it sets a trap enable for each exception, a control that flushes denormal operands to zero, and a two-bit rounding mode. The flush control and the rounding mode are also driven out to the arithmetic unit. A trap-request output rises when the latest operation raised an exception whose enable is set. It also rises when the operation was unimplemented, whatever the enables say. A read-only summary bit shows at a glance whether any of four serious exceptions has occurred since the flags were last cleared. Inexact is not part of the summary.

Bits are numbered with bit 0 as the most significant bit, so numbered bit k sits at data-bus index 31-k.

Top module: `fp_exc_status_reg`

## Requirements
- R1: After a clock edge with `rst_n` low, the read word is 0, `trap_req` is 0, `round_mode` is 0 and `flush_zero` is 0.
- R2: Numbered bits 1 to 5 (bus indices 30 down to 26) are sticky flags. In order they are inexact, underflow, divide-by-zero, overflow and invalid, matching `op_exc[4:0]`. A flag is set on the edge where `op_done` is high and its `op_exc` bit is 1. A later operation without that exception leaves it set.
- R3: Numbered bits 25 to 29 (bus indices 6 to 2, same exception order) and the unimplemented cause at numbered bit 24 (bus index 7) are loaded from `op_exc` and `op_unimpl` on every edge where `op_done` is high. This overwrites them, including with zero.
- R4: Numbered bit 0 (bus index 31) reads as the OR of the underflow, divide-by-zero, overflow and invalid sticky flags. A set inexact flag on its own leaves it 0.
- R5: Numbered bits 17 to 21 (bus indices 14 to 10, same exception order) are trap enables. `trap_req` is 1 when some cause bit and its enable are both 1. A cause whose enable is 0 does not raise it.
- R6: A set unimplemented cause bit raises `trap_req` regardless of the enables.
- R7: A software write (`sw_wr_en` high) loads the sticky flags, enables, flush control, cause bits, unimplemented cause and rounding mode from `sw_wr_data`. Writing 0 to the sticky flags clears them.
- R8: When `op_done` and `sw_wr_en` are high on the same edge, the operation's exceptions still set their sticky flags and the cause bits take the operation's values. All other fields take the written values.
- R9: Numbered bits 6 to 16 and 22 (bus indices 25 to 15 and 9) always read 0. The summary bit cannot be written.
- R10: `flush_zero` follows numbered bit 23 (bus index 8) and `round_mode` follows numbered bits 30 to 31 (bus indices 1 to 0).
- R11: On the edge where an enabled exception is recorded, its sticky flag is set. In the cycle after that edge, `trap_req` and the flag are visible together.
- R12: `op_exc` and `op_unimpl` have no effect while `op_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write word |
| sw_rd_data | output | 32 | Current register word |
| op_done | input | 1 | Arithmetic operation completed this cycle |
| op_exc | input | 5 | Exceptions of that operation: inexact, underflow, div-by-zero, overflow, invalid (bit 4 to 0) |
| op_unimpl | input | 1 | That operation is unimplemented |
| round_mode | output | 2 | Rounding-mode field |
| flush_zero | output | 1 | Treat denormals as zero |
| trap_req | output | 1 | Enabled exception or unimplemented operation pending |

## Verification
The assertions assume that `op_exc` and `op_unimpl` only matter on cycles where `op_done` is high. They also assume that a software write may coincide with a completed operation, with the operation taking precedence for flags and causes. The properties that look one cycle ahead assume that reset is not asserted in the following cycle, and the reset condition turns them off. The stimulus changes inputs only just after a rising edge and pulses each strobe for one cycle. It deliberately includes a coincident write and operation, as well as exception inputs presented while `op_done` is low, so that the assumption about ignored inputs is itself exercised.

// File: rtl/fp_exc_pkg.sv
// Package: field layout and shared types of the floating-point exception
// status register. Positions are data-bus indices (numbered bit k = index 31-k).
// Assumes exception order inexact, underflow, div-by-zero, overflow, invalid
// from high to low index inside every five-bit field.
package fp_exc_pkg;
    localparam int XLEN      = 32;
    localparam int NUM_EXC   = 5;
    localparam int RM_W      = 2;

    localparam int POS_SUM    = 31;
    localparam int POS_STK_HI = 30;
    localparam int POS_EN_HI  = 14;
    localparam int POS_FLUSH  = 8;
    localparam int POS_UNIMPL = 7;
    localparam int POS_CAU_HI = 6;
    localparam int POS_RM_HI  = 1;

    localparam int POS_STK_LO = POS_STK_HI - NUM_EXC + 1;
    localparam int POS_EN_LO  = POS_EN_HI - NUM_EXC + 1;
    localparam int POS_CAU_LO = POS_CAU_HI - NUM_EXC + 1;

    // Exceptions that contribute to the summary bit: all but inexact (MSB).
    localparam logic [NUM_EXC-1:0] SUM_MASK = {1'b0, {(NUM_EXC-1){1'b1}}};

    typedef logic [NUM_EXC-1:0] exc_vec_t;
    typedef logic [RM_W-1:0]    rmode_t;
endpackage

// File: rtl/fp_exc_sticky_bank.sv
// Sticky exception flags, one flop per exception built by generate.
// Hardware can only set a flag; software loads the whole field.
// Assumes a hardware set wins over a software value in the same cycle.
module fp_exc_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_load,
    input  logic [N-1:0] sw_val,
    input  logic         hw_set_en,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One flag: reset, hardware set, then software load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (hw_set_en && hw_set[g]) begin
                flags[g] <= 1'b1;
            end else if (sw_load) begin
                flags[g] <= sw_val[g];
            end
        end
    end
endmodule

// File: rtl/fp_exc_ctrl_regs.sv
// Enables, flush control, rounding mode and per-operation cause bits.
// Causes follow the completed operation; software may write them otherwise.
// Assumes an operation completion has priority over software for causes.
module fp_exc_ctrl_regs
    import fp_exc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_load,
    input  exc_vec_t sw_en,
    input  logic     sw_flush,
    input  rmode_t   sw_rm,
    input  exc_vec_t sw_cause,
    input  logic     sw_unimpl,
    input  logic     op_done,
    input  exc_vec_t op_exc,
    input  logic     op_unimpl,
    output exc_vec_t en,
    output logic     flush,
    output rmode_t   rm,
    output exc_vec_t cause,
    output logic     unimpl
);
    // Software-only configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= '0;
            flush <= 1'b0;
            rm    <= '0;
        end else if (sw_load) begin
            en    <= sw_en;
            flush <= sw_flush;
            rm    <= sw_rm;
        end
    end

    // Cause bits: overwritten by each completed operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause  <= '0;
            unimpl <= 1'b0;
        end else if (op_done) begin
            cause  <= op_exc;
            unimpl <= op_unimpl;
        end else if (sw_load) begin
            cause  <= sw_cause;
            unimpl <= sw_unimpl;
        end
    end
endmodule

// File: rtl/fp_exc_trap_eval.sv
// Trap request: any cause with its enable set, or an unimplemented operation.
// Assumes inputs come straight from registers, so the output is glitch-safe
// for a synchronous consumer.
module fp_exc_trap_eval #(
    parameter int N = 5
) (
    input  logic [N-1:0] cause,
    input  logic [N-1:0] en,
    input  logic         unimpl,
    output logic         trap
);
    // Combine masked causes with the unconditional unimplemented cause.
    always_comb begin
        trap = unimpl;
        for (int i = 0; i < N; i++) begin
            trap = trap | (cause[i] & en[i]);
        end
    end
endmodule

// File: rtl/fp_exc_read_mux.sv
// Assembles the 32-bit read word and the summary bit.
// Assumes every position not listed in the package reads as zero.
module fp_exc_read_mux
    import fp_exc_pkg::*;
(
    input  exc_vec_t          sticky,
    input  exc_vec_t          en,
    input  logic              flush,
    input  rmode_t            rm,
    input  exc_vec_t          cause,
    input  logic              unimpl,
    output logic [XLEN-1:0]   word
);
    // Place each field; summary leaves out the inexact flag.
    always_comb begin
        word                         = '0;
        word[POS_SUM]                = |(sticky & SUM_MASK);
        word[POS_STK_HI:POS_STK_LO]  = sticky;
        word[POS_EN_HI:POS_EN_LO]    = en;
        word[POS_FLUSH]              = flush;
        word[POS_UNIMPL]             = unimpl;
        word[POS_CAU_HI:POS_CAU_LO]  = cause;
        word[POS_RM_HI:0]            = rm;
    end
endmodule

// File: rtl/fp_exc_status_reg.sv
// Top: floating-point exception status and control register.
// Records completed-operation exceptions as sticky flags and cause bits,
// exposes enables, flush control and rounding mode, and raises a trap request.
// Assumes op_exc/op_unimpl are valid only while op_done is high.
module fp_exc_status_reg
    import fp_exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [XLEN-1:0]  sw_wr_data,
    output logic [XLEN-1:0]  sw_rd_data,
    input  logic             op_done,
    input  logic [NUM_EXC-1:0] op_exc,
    input  logic             op_unimpl,
    output logic [RM_W-1:0]  round_mode,
    output logic             flush_zero,
    output logic             trap_req
);
    exc_vec_t sticky, en, cause;
    logic     flush, unimpl;
    rmode_t   rm;

    fp_exc_sticky_bank #(.N(NUM_EXC)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_load   (sw_wr_en),
        .sw_val    (sw_wr_data[POS_STK_HI:POS_STK_LO]),
        .hw_set_en (op_done),
        .hw_set    (op_exc),
        .flags     (sticky)
    );

    fp_exc_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_load   (sw_wr_en),
        .sw_en     (sw_wr_data[POS_EN_HI:POS_EN_LO]),
        .sw_flush  (sw_wr_data[POS_FLUSH]),
        .sw_rm     (sw_wr_data[POS_RM_HI:0]),
        .sw_cause  (sw_wr_data[POS_CAU_HI:POS_CAU_LO]),
        .sw_unimpl (sw_wr_data[POS_UNIMPL]),
        .op_done   (op_done),
        .op_exc    (op_exc),
        .op_unimpl (op_unimpl),
        .en        (en),
        .flush     (flush),
        .rm        (rm),
        .cause     (cause),
        .unimpl    (unimpl)
    );

    fp_exc_trap_eval #(.N(NUM_EXC)) u_trap (
        .cause  (cause),
        .en     (en),
        .unimpl (unimpl),
        .trap   (trap_req)
    );

    fp_exc_read_mux u_rd (
        .sticky (sticky),
        .en     (en),
        .flush  (flush),
        .rm     (rm),
        .cause  (cause),
        .unimpl (unimpl),
        .word   (sw_rd_data)
    );

    assign round_mode = rm;
    assign flush_zero = flush;
endmodule

// File: rtl/fp_exc_status_chk.sv
// Checker for fp_exc_status_reg, attached by bind. Observes ports only.
// Assumes reset is held low for at least one edge at start-up.
module fp_exc_status_chk
    import fp_exc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr_en,
    input logic [XLEN-1:0]  sw_wr_data,
    input logic [XLEN-1:0]  sw_rd_data,
    input logic             op_done,
    input logic [NUM_EXC-1:0] op_exc,
    input logic             op_unimpl,
    input logic [RM_W-1:0]  round_mode,
    input logic             flush_zero,
    input logic             trap_req
);
    localparam logic [XLEN-1:0] RSV_MASK = 32'h03FF_8200;

    // R2 / R8: an operation's exceptions end up in the sticky field
    p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((sw_rd_data[POS_STK_HI:POS_STK_LO] & $past(op_exc)) == $past(op_exc)));

    // R3: causes mirror the last completed operation
    p_cause_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (sw_rd_data[POS_CAU_HI:POS_CAU_LO] == $past(op_exc)
                     && sw_rd_data[POS_UNIMPL] == $past(op_unimpl)));

    // R4: summary bit versus the four serious sticky flags
    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_data[POS_SUM] == |sw_rd_data[POS_STK_HI-1:POS_STK_LO]);

    // R5: with all enables clear and no unimplemented cause, no trap
    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd_data[POS_EN_HI:POS_EN_LO] == '0 && !sw_rd_data[POS_UNIMPL]) |-> !trap_req);

    // R6: unimplemented cause always traps
    p_unimpl_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_data[POS_UNIMPL] |-> trap_req);

    // R9: reserved positions read zero
    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd_data & RSV_MASK) == '0);

    // R10: configuration outputs follow a software write
    p_cfg_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (round_mode == $past(sw_wr_data[POS_RM_HI:0])
                      && flush_zero == $past(sw_wr_data[POS_FLUSH])));

    // R12: no operation and no write leaves the word unchanged
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !sw_wr_en) |=> $stable(sw_rd_data));
endmodule

bind fp_exc_status_reg fp_exc_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .sw_rd_data (sw_rd_data),
    .op_done    (op_done),
    .op_exc     (op_exc),
    .op_unimpl  (op_unimpl),
    .round_mode (round_mode),
    .flush_zero (flush_zero),
    .trap_req   (trap_req)
);

// File: tb/tb_fp_exc_status_reg.sv
`timescale 1ns/1ps
// Bench for fp_exc_status_reg: a vector table walked by one loop, then
// directed reset and output checks.
module tb_fp_exc_status_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [31:0] sw_wr_data;
    logic [31:0] sw_rd_data;
    logic        op_done;
    logic [4:0]  op_exc;
    logic        op_unimpl;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic        trap_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_exc_status_reg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .sw_rd_data (sw_rd_data),
        .op_done    (op_done),
        .op_exc     (op_exc),
        .op_unimpl  (op_unimpl),
        .round_mode (round_mode),
        .flush_zero (flush_zero),
        .trap_req   (trap_req)
    );

    // Word from fields as laid out in the requirements (summary from R4).
    function automatic logic [31:0] mk(logic [4:0] st, logic [4:0] en, logic fl,
                                       logic un, logic [4:0] ca, logic [1:0] rm);
        logic [31:0] w;
        w        = '0;
        w[31]    = |st[3:0];
        w[30:26] = st;
        w[14:10] = en;
        w[8]     = fl;
        w[7]     = un;
        w[6:2]   = ca;
        w[1:0]   = rm;
        return w;
    endfunction

    typedef struct packed {
        logic        wr;
        logic [31:0] wdata;
        logic        od;
        logic [4:0]  exc;
        logic        un;
        logic [31:0] exp_rd;
        logic        exp_trap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // 0 R2 R4: inexact only, summary stays 0, not enabled
        '{1'b0, 32'h0, 1'b1, 5'b10000, 1'b0, mk(5'b10000, 5'b0, 1'b0, 1'b0, 5'b10000, 2'b00), 1'b0},
        // 1 R3: clean op clears causes, sticky stays
        '{1'b0, 32'h0, 1'b1, 5'b00000, 1'b0, mk(5'b10000, 5'b0, 1'b0, 1'b0, 5'b00000, 2'b00), 1'b0},
        // 2 R7: enable div-by-zero, flush, rounding mode 2
        '{1'b1, mk(5'b10000, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b10), 1'b0, 5'b0, 1'b0,
          mk(5'b10000, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b10), 1'b0},
        // 3 R5 R11: enabled div-by-zero traps, sticky set together
        '{1'b0, 32'h0, 1'b1, 5'b00100, 1'b0, mk(5'b10100, 5'b00100, 1'b1, 1'b0, 5'b00100, 2'b10), 1'b1},
        // 4 R5: overflow masked
        '{1'b0, 32'h0, 1'b1, 5'b00010, 1'b0, mk(5'b10110, 5'b00100, 1'b1, 1'b0, 5'b00010, 2'b10), 1'b0},
        // 5 R6: unimplemented traps
        '{1'b0, 32'h0, 1'b1, 5'b00000, 1'b1, mk(5'b10110, 5'b00100, 1'b1, 1'b1, 5'b00000, 2'b10), 1'b1},
        // 6 R7: software clears sticky and unimplemented cause
        '{1'b1, mk(5'b0, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b10), 1'b0, 5'b0, 1'b0,
          mk(5'b0, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b10), 1'b0},
        // 7 R9: reserved bits and summary written as 1, read 0
        '{1'b1, mk(5'b0, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b01) | 32'h83FF_8200, 1'b0, 5'b0, 1'b0,
          mk(5'b0, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b01), 1'b0},
        // 8 R8: write clearing sticky coincides with underflow+invalid
        '{1'b1, mk(5'b0, 5'b00100, 1'b1, 1'b0, 5'b0, 2'b01), 1'b1, 5'b01001, 1'b0,
          mk(5'b01001, 5'b00100, 1'b1, 1'b0, 5'b01001, 2'b01), 1'b0},
        // 9 R12: exceptions without op_done ignored
        '{1'b0, 32'h0, 1'b0, 5'b11111, 1'b1, mk(5'b01001, 5'b00100, 1'b1, 1'b0, 5'b01001, 2'b01), 1'b0}
    };

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; returns just after the edge.
    task automatic apply(logic wr, logic [31:0] wd, logic od, logic [4:0] ex, logic un);
        sw_wr_en = wr; sw_wr_data = wd; op_done = od; op_exc = ex; op_unimpl = un;
        @(posedge clk);
        #1;
        sw_wr_en = 1'b0; sw_wr_data = '0; op_done = 1'b0; op_exc = '0; op_unimpl = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0;
        op_done = 1'b0; op_exc = '0; op_unimpl = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        check32("R1 word",  sw_rd_data, 32'h0);
        check32("R1 trap",  {31'b0, trap_req}, 32'h0);
        check32("R1 rmode", {30'b0, round_mode}, 32'h0);
        check32("R1 flush", {31'b0, flush_zero}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].wr, VEC[i].wdata, VEC[i].od, VEC[i].exc, VEC[i].un);
            check32($sformatf("vector %0d word", i), sw_rd_data, VEC[i].exp_rd);
            check32($sformatf("vector %0d trap", i), {31'b0, trap_req}, {31'b0, VEC[i].exp_trap});
        end

        // R10: configuration outputs after vector 9
        check32("R10 rmode", {30'b0, round_mode}, 32'h1);
        check32("R10 flush", {31'b0, flush_zero}, 32'h1);

        // R6: unimplemented with every enable clear still traps
        apply(1'b1, 32'h0, 1'b0, 5'b0, 1'b0);
        apply(1'b0, 32'h0, 1'b1, 5'b11111, 1'b1);
        check32("R6 trap no enables", {31'b0, trap_req}, 32'h1);
        check32("R2 R3 all flags", sw_rd_data, mk(5'b11111, 5'b0, 1'b0, 1'b1, 5'b11111, 2'b00));

        // R5: invalid enabled alone, invalid cause alone traps
        apply(1'b1, mk(5'b0, 5'b00001, 1'b0, 1'b0, 5'b0, 2'b11), 1'b0, 5'b0, 1'b0);
        apply(1'b0, 32'h0, 1'b1, 5'b00001, 1'b0);
        check32("R5 invalid enabled trap", {31'b0, trap_req}, 32'h1);
        check32("R4 summary from invalid", {31'b0, sw_rd_data[31]}, 32'h1);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check32("R1 mid reset word", sw_rd_data, 32'h0);
        check32("R1 mid reset trap", {31'b0, trap_req}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule